// File: doc/BRIEF.md
# Clock Failure Monitor with Automatic Fallback

This block chooses the system clock from two sources: an internal oscillator that always runs, and an external clock that may stop. After reset the internal oscillator drives the output. Software can request the external clock with a select bit. Switching in either direction happens through a glitch-free multiplexer. The branch that is currently on is turned off on a falling edge of its own clock. Only after that is the other branch turned on, on a falling edge of its own clock.

While the external clock is requested or in use, a watchdog counter in the internal clock domain checks that external edges keep arriving. Each external rising edge flips a toggle flag. A two-flop synchronizer carries that flag into the internal domain, and any change seen there restarts the window. If 64 internal cycles pass with no change, the block declares a failure. It then forces the selection back to the internal oscillator and sets a sticky failure flag. An interrupt output follows that flag when the interrupt is enabled. The select bit has no effect until software clears the flag by pulsing the clear input.

All control and status pins are plain levels, sampled or produced in the internal clock domain. There is no data stream, so no valid/ready handshake applies.

Top module: `clk_fail_mon`

## Requirements
- R1: After reset the internal oscillator drives `clk_out`, `src_is_ext` is 0, `fail_flag` is 0 and `irq` is 0.
- R2: With `sel_ext` at 1 and a running external clock, `clk_out` carries the external clock and `src_is_ext` becomes 1.
- R3: Returning `sel_ext` to 0 moves `clk_out` back to the internal oscillator, and `src_is_ext` returns to 0.
- R4: The output clock never shows a high or low pulse shorter than half a period of the internal oscillator. The two branch enables are never both on.
- R5: While the external clock is requested or in use, a failure is declared when no external edge has been seen for a window of WINDOW (default 64) internal cycles. No failure is declared earlier in that window.
- R6: On a failure, the selection returns to the internal oscillator without software action, and `src_is_ext` reads 0.
- R7: `irq` is 1 exactly when `fail_flag` is 1 and `irq_en` is 1. A failure with `irq_en` at 0 leaves `irq` at 0.
- R8: While `fail_flag` is 1, `sel_ext` is ignored. A one-cycle pulse of 1 on `fail_clr` clears the flag, and the select bit then takes effect again.
- R9: While the internal oscillator is selected, a stopped external clock causes no failure.
- R10: `src_is_ext` changes to 1 only after the internal branch is off and the external branch is on. It stays 0 during the first cycles of a switch.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_int | input | 1 | Internal oscillator; always running; timebase for control and monitoring |
| clk_ext | input | 1 | External clock; may stop |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_ext | input | 1 | Software request: 1 selects the external clock, 0 the internal |
| irq_en | input | 1 | Interrupt enable for failure events |
| fail_clr | input | 1 | Write-one pulse that clears the failure flag |
| clk_out | output | 1 | Selected system clock |
| src_is_ext | output | 1 | 1 when the external clock drives `clk_out` |
| fail_flag | output | 1 | Sticky record of a detected external clock failure |
| irq | output | 1 | Failure interrupt, gated by `irq_en` |

## Verification
A corrupted selection state appears at `clk_out` as the wrong edge rate, and within about ten internal cycles as a `src_is_ext` value that disagrees with the request. A bad enable handover shows up as a short high or low pulse on `clk_out` during the switch itself. A fault in the window counter moves the cycle at which `fail_flag` rises. The checks therefore bracket that cycle between 40 and 90 internal cycles after the external clock stops. A flag that fails to hold or to clear shows up on `irq` and on an ignored or honoured `sel_ext` within a few tens of cycles.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
  localparam int CFM_WINDOW_DEF = 64;
  localparam int CFM_SYNC_DEF   = 2;
endpackage

// File: rtl/cfm_sync.sv
module cfm_sync #(
  parameter int STAGES = cfm_pkg::CFM_SYNC_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cfm_edge_mon.sv
module cfm_edge_mon #(
  parameter int WINDOW = cfm_pkg::CFM_WINDOW_DEF,
  parameter int SYNC   = cfm_pkg::CFM_SYNC_DEF
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic active,
  input  logic clr,
  output logic fail_set,
  output logic fail_flag
);
  localparam int CW = $clog2(WINDOW + 1);
  localparam logic [CW-1:0] LAST = CW'(WINDOW - 1);

  logic          ext_tgl;
  logic          tgl_s;
  logic          tgl_d;
  logic          edge_seen;
  logic [CW-1:0] cnt;

  // external domain: flip on every rising edge
  always_ff @(posedge clk_ext or negedge rst_n) begin
    if (!rst_n) ext_tgl <= 1'b0;
    else        ext_tgl <= ~ext_tgl;
  end

  cfm_sync #(.STAGES(SYNC)) u_tgl_sync (
    .clk(clk_int), .rst_n(rst_n), .d(ext_tgl), .q(tgl_s)
  );

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) tgl_d <= 1'b0;
    else        tgl_d <= tgl_s;
  end

  assign edge_seen = tgl_s ^ tgl_d;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)                  cnt <= '0;
    else if (!active || edge_seen) cnt <= '0;
    else if (cnt != LAST)        cnt <= cnt + 1'b1;
  end

  assign fail_set = active && !edge_seen && (cnt == LAST);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)        fail_flag <= 1'b0;
    else if (fail_set) fail_flag <= 1'b1;
    else if (clr)      fail_flag <= 1'b0;
  end

  // R9: a failure is only raised while monitoring is active
  assert_active_only_R9: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(fail_flag) |-> $past(active));

  // R5: the flag rises only at the end of a full empty window
  assert_window_R5: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(fail_flag) |-> ($past(cnt) == LAST));

  // R8: the flag is sticky until cleared
  assert_flag_sticky_R8: assert property (@(posedge clk_int) disable iff (!rst_n)
    (fail_flag && !clr) |=> fail_flag);
endmodule

// File: rtl/cfm_glitch_mux.sv
module cfm_glitch_mux #(
  parameter int SYNC = cfm_pkg::CFM_SYNC_DEF
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic kill_ext,
  input  logic want_ext,
  output logic clk_out,
  output logic int_on,
  output logic ext_seen,
  output logic src_is_ext
);
  logic en_int;
  logic en_ext;
  logic req_ext_q;
  logic req_ext_s;
  logic ext_rst_n;

  // the external branch is cleared without its clock on a failure
  assign ext_rst_n = rst_n & ~kill_ext;

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) req_ext_q <= 1'b0;
    else        req_ext_q <= want_ext && !en_int;
  end

  cfm_sync #(.STAGES(SYNC)) u_req_sync (
    .clk(clk_ext), .rst_n(ext_rst_n), .d(req_ext_q), .q(req_ext_s)
  );

  always_ff @(negedge clk_ext or negedge ext_rst_n) begin
    if (!ext_rst_n) en_ext <= 1'b0;
    else            en_ext <= req_ext_s;
  end

  cfm_sync #(.STAGES(SYNC)) u_ack_sync (
    .clk(clk_int), .rst_n(rst_n), .d(en_ext), .q(ext_seen)
  );

  always_ff @(negedge clk_int or negedge rst_n) begin
    if (!rst_n) en_int <= 1'b1;
    else        en_int <= !want_ext && !ext_seen;
  end

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n) src_is_ext <= 1'b0;
    else        src_is_ext <= ext_seen && !en_int;
  end

  assign clk_out = (clk_int & en_int) | (clk_ext & en_ext);
  assign int_on  = en_int;

  // R4: never both branches on
  assert_exclusive_R4: assert property (@(posedge clk_int) disable iff (!rst_n)
    !(en_int && en_ext));

  // R10: status rises only once the internal branch is off
  assert_status_after_switch_R10: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(src_is_ext) |-> !en_int);
endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon #(
  parameter int WINDOW = cfm_pkg::CFM_WINDOW_DEF,
  parameter int SYNC   = cfm_pkg::CFM_SYNC_DEF
) (
  input  logic clk_int,
  input  logic clk_ext,
  input  logic rst_n,
  input  logic sel_ext,
  input  logic irq_en,
  input  logic fail_clr,
  output logic clk_out,
  output logic src_is_ext,
  output logic fail_flag,
  output logic irq
);
  logic want_r;
  logic fail_set;
  logic int_on;
  logic ext_seen;
  logic done;

  cfm_edge_mon #(.WINDOW(WINDOW), .SYNC(SYNC)) u_mon (
    .clk_int  (clk_int),
    .clk_ext  (clk_ext),
    .rst_n    (rst_n),
    .active   (want_r && !fail_flag),
    .clr      (fail_clr),
    .fail_set (fail_set),
    .fail_flag(fail_flag)
  );

  cfm_glitch_mux #(.SYNC(SYNC)) u_mux (
    .clk_int   (clk_int),
    .clk_ext   (clk_ext),
    .rst_n     (rst_n),
    .kill_ext  (fail_flag),
    .want_ext  (want_r),
    .clk_out   (clk_out),
    .int_on    (int_on),
    .ext_seen  (ext_seen),
    .src_is_ext(src_is_ext)
  );

  // a new request is accepted only once the previous switch has settled
  assign done = want_r ? src_is_ext : (int_on && !ext_seen);

  always_ff @(posedge clk_int or negedge rst_n) begin
    if (!rst_n)        want_r <= 1'b0;
    else if (fail_set) want_r <= 1'b0;
    else if (done)     want_r <= sel_ext && !fail_flag;
  end

  assign irq = fail_flag & irq_en;

  // R6: a failure drops the external request in the same cycle
  assert_fallback_R6: assert property (@(posedge clk_int) disable iff (!rst_n)
    $rose(fail_flag) |-> !want_r);
endmodule

// File: tb/clk_fail_mon_tb.sv
`timescale 1ns/1ps
module clk_fail_mon_tb;
  logic clk_int = 1'b0;
  logic clk_ext = 1'b0;
  logic rst_n = 1'b0;
  logic sel_ext = 1'b0;
  logic irq_en = 1'b0;
  logic fail_clr = 1'b0;
  logic ext_run = 1'b1;
  logic clk_out, src_is_ext, fail_flag, irq;

  int n_chk = 0;
  int n_bad = 0;
  int edges = 0;
  bit track = 1'b0;
  realtime last_t = 0.0;
  realtime min_w = 1000.0;

  always #2.5 clk_int = ~clk_int;
  always #6 clk_ext = ext_run ? ~clk_ext : 1'b0;

  clk_fail_mon u_dut (
    .clk_int(clk_int), .clk_ext(clk_ext), .rst_n(rst_n),
    .sel_ext(sel_ext), .irq_en(irq_en), .fail_clr(fail_clr),
    .clk_out(clk_out), .src_is_ext(src_is_ext),
    .fail_flag(fail_flag), .irq(irq)
  );

  always @(posedge clk_out) edges++;

  always @(clk_out) begin
    if (track) begin
      if (last_t > 0.0 && ($realtime - last_t) < min_w) min_w = $realtime - last_t;
      last_t = $realtime;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk_int);
    #1;
  endtask

  task automatic rate_check(input bool_ext, input string req);
    int got;
    int exp;
    exp = bool_ext ? 50 : 120;
    edges = 0;
    #600;
    got = edges;
    check(got >= exp - 2 && got <= exp + 2, req, got, exp);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    step(10);
    rst_n = 1'b1;
    step(5);
    track = 1'b1;
    check(src_is_ext == 1'b0, "R1 status", src_is_ext, 0);
    check(fail_flag == 1'b0, "R1 flag", fail_flag, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    rate_check(1'b0, "R1 rate");
  endtask

  task automatic t_to_ext;
    sel_ext = 1'b1;
    step(2);
    check(src_is_ext == 1'b0, "R10 early status", src_is_ext, 0);
    step(40);
    check(src_is_ext == 1'b1, "R2 status", src_is_ext, 1);
    rate_check(1'b1, "R2 rate");
  endtask

  task automatic t_to_int;
    sel_ext = 1'b0;
    step(40);
    check(src_is_ext == 1'b0, "R3 status", src_is_ext, 0);
    rate_check(1'b0, "R3 rate");
  endtask

  task automatic t_int_no_monitor;
    ext_run = 1'b0;
    step(200);
    check(fail_flag == 1'b0, "R9 flag", fail_flag, 0);
    ext_run = 1'b1;
    step(10);
  endtask

  task automatic t_failure;
    irq_en = 1'b1;
    sel_ext = 1'b1;
    step(40);
    check(src_is_ext == 1'b1, "R2 status before stop", src_is_ext, 1);
    ext_run = 1'b0;
    step(40);
    check(fail_flag == 1'b0, "R5 early", fail_flag, 0);
    step(50);
    check(fail_flag == 1'b1, "R5 declared", fail_flag, 1);
    step(10);
    check(src_is_ext == 1'b0, "R6 status", src_is_ext, 0);
    check(irq == 1'b1, "R7 irq on", irq, 1);
    rate_check(1'b0, "R6 rate");
  endtask

  task automatic t_select_ignored;
    ext_run = 1'b1;
    step(40);
    check(src_is_ext == 1'b0, "R8 ignored", src_is_ext, 0);
    sel_ext = 1'b0;
    step(5);
    sel_ext = 1'b1;
    step(40);
    check(src_is_ext == 1'b0, "R8 ignored toggle", src_is_ext, 0);
    check(fail_flag == 1'b1, "R8 sticky", fail_flag, 1);
  endtask

  task automatic t_clear;
    fail_clr = 1'b1;
    step(1);
    fail_clr = 1'b0;
    step(2);
    check(fail_flag == 1'b0, "R8 cleared", fail_flag, 0);
    check(irq == 1'b0, "R7 irq off", irq, 0);
    step(40);
    check(src_is_ext == 1'b1, "R8 select restored", src_is_ext, 1);
  endtask

  task automatic t_irq_masked;
    irq_en = 1'b0;
    ext_run = 1'b0;
    step(100);
    check(fail_flag == 1'b1, "R7 flag masked", fail_flag, 1);
    check(irq == 1'b0, "R7 masked", irq, 0);
    check(src_is_ext == 1'b0, "R6 masked", src_is_ext, 0);
    irq_en = 1'b1;
    step(1);
    check(irq == 1'b1, "R7 enable later", irq, 1);
    ext_run = 1'b1;
    sel_ext = 1'b0;
    fail_clr = 1'b1;
    step(1);
    fail_clr = 1'b0;
    step(40);
    check(fail_flag == 1'b0, "R8 clear idle", fail_flag, 0);
    check(src_is_ext == 1'b0, "R3 idle", src_is_ext, 0);
    rate_check(1'b0, "R3 idle rate");
  endtask

  initial begin
    #2_000_000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_to_ext();
    t_to_int();
    t_int_no_monitor();
    t_failure();
    t_select_ignored();
    t_clear();
    t_irq_masked();
    check(min_w >= 2.4, "R4 min pulse ps", int'(min_w * 1000.0), 2500);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule